// File: doc/BRIEF.md
# Multi-Mode 8-Bit Barrel Shifter

This block is a combinational shifter with six selectable operations. It takes an 8-bit data word, a 3-bit shift distance and a 3-bit operation code. The result appears on the output in the same evaluation. No clock is used and no state is kept.

The datapath is a log-depth cascade of three mux stages. The stages move the word right by 1, 2 and 4 places, each controlled by one bit of the distance. Left-going operations reverse the bit order before the cascade and again after it, so a single right-moving cascade serves both directions.

Each stage picks its fill bits from one of three sources, depending on the operation:
- zeros, for the logical shifts;
- a copy of the sign bit, for the arithmetic shift;
- the bits that wrap around, for the rotates.

Two operation codes are unused. Both of them fall back to passing the input through unchanged.

Top module: `barrel_mux8`

## Requirements
- R1: With op = 3'b000 the output equals the data input for every distance.
- R2: With op = 3'b001 (logical left) the output is the input moved toward the MSB by the distance. Zeros enter at bit 0 and bits carried past bit 7 are lost.
- R3: With op = 3'b010 (logical right) the output is the input moved toward the LSB by the distance, with zeros entering at bit 7.
- R4: With op = 3'b011 (arithmetic right) the input moves toward the LSB and input bit 7 is copied into every vacated place. For example, 0x81 by 1 gives 0xC0.
- R5: With op = 3'b100 (rotate left) bits leaving bit 7 re-enter at bit 0, and no bit is lost.
- R6: With op = 3'b101 (rotate right) bits leaving bit 0 re-enter at bit 7, and no bit is lost.
- R7: Codes 3'b110 and 3'b111 behave exactly like 3'b000.
- R8: A distance of 0 returns the input unchanged under every operation code.
- R9: When all inputs are known, the output carries no X or Z bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | 8 | Data word to be shifted or rotated |
| amt  | input  | 3 | Shift distance, 0 to 7 |
| op   | input  | 3 | Operation code |
| dout | output | 8 | Result |

## Verification
Directed words are chosen so that each one exposes a specific fault:
- 0x81 has both end bits set, so it separates zero fill from sign fill and from wrapped fill.
- 0x96 has an irregular pattern, so it shows up a rotate in the wrong direction or by the wrong distance.
- 0xFF at distance 7 checks fill width at the far end of the range.

After these, an exhaustive sweep covers all 256 words, all 8 distances and all 8 codes, including both reserved codes. This sweep catches any stage that is wired to the wrong distance bit.

// File: rtl/barrel_mux8.sv
module barrel_mux8 #(
  parameter int WIDTH = 8,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] dout
);
  localparam logic [2:0] OP_PASS = 3'b000;
  localparam logic [2:0] OP_LSL  = 3'b001;
  localparam logic [2:0] OP_LSR  = 3'b010;
  localparam logic [2:0] OP_ASR  = 3'b011;
  localparam logic [2:0] OP_ROL  = 3'b100;
  localparam logic [2:0] OP_ROR  = 3'b101;

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    for (int i = 0; i < WIDTH; i++) flip[i] = v[WIDTH-1-i];
  endfunction

  logic             go_left, wrap, active, sgn;
  logic [WIDTH-1:0] stg [SHW+1];
  logic [WIDTH-1:0] shifted;

  assign go_left = (op == OP_LSL) || (op == OP_ROL);
  assign wrap    = (op == OP_ROL) || (op == OP_ROR);
  assign active  = (op >= OP_LSL) && (op <= OP_ROR);
  assign sgn     = (op == OP_ASR) & din[WIDTH-1];

  assign stg[0] = go_left ? flip(din) : din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [D-1:0] fill;
    assign fill       = wrap ? stg[k][D-1:0] : {D{sgn}};
    assign stg[k + 1] = amt[k] ? {fill, stg[k][WIDTH-1:D]} : stg[k];
  end

  assign shifted = go_left ? flip(stg[SHW]) : stg[SHW];
  assign dout    = active ? shifted : din;

  always_comb begin
    if (!$isunknown({din, amt, op})) begin
      AST_NO_X: assert (!$isunknown(dout)); // R9
      if (op == OP_PASS)
        AST_PASS_IDENT: assert (dout == din); // R1
      if (op == OP_LSL && amt != '0)
        AST_LSL_LOW_ZERO: assert (dout[0] == 1'b0); // R2
      if (op == OP_LSR && amt != '0)
        AST_LSR_TOP_ZERO: assert (dout[WIDTH-1] == 1'b0); // R3
      if (op == OP_ASR)
        AST_ASR_SIGN_KEPT: assert (dout[WIDTH-1] == din[WIDTH-1]); // R4
      if (op == OP_ROL)
        AST_ROL_POPCOUNT: assert ($countones(dout) == $countones(din)); // R5
      if (op == OP_ROR)
        AST_ROR_POPCOUNT: assert ($countones(dout) == $countones(din)); // R6
      if (op[2:1] == 2'b11)
        AST_RSVD_PASS: assert (dout == din); // R7
      if (amt == '0)
        AST_ZERO_AMT_IDENT: assert (dout == din); // R8
    end
  end
endmodule

// File: tb/barrel_mux8_bench.sv
`timescale 1ns/1ps
module barrel_mux8_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] din = 8'h00;
  logic [2:0] amt = 3'd0;
  logic [2:0] op  = 3'd0;
  logic [7:0] dout;
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  barrel_mux8 u_barrel_mux8 (.din(din), .amt(amt), .op(op), .dout(dout));

  function automatic logic [7:0] model(input logic [7:0] x, input logic [2:0] s,
                                       input logic [2:0] o);
    logic [15:0] dbl;
    dbl = {x, x};
    case (o)
      3'b001:  model = x << s;
      3'b010:  model = x >> s;
      3'b011:  model = $unsigned($signed(x) >>> s);
      3'b100:  begin dbl = dbl << s; model = dbl[15:8]; end
      3'b101:  begin dbl = dbl >> s; model = dbl[7:0]; end
      default: model = x;
    endcase
  endfunction

  task automatic apply(input string req, input logic [7:0] x, input logic [2:0] s,
                       input logic [2:0] o, input logic [7:0] exp);
    @(negedge clk);
    din = x; amt = s; op = o;
    #1;
    n_vec++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: din=%h amt=%0d op=%b got %h expected %h", req, x, s, o, dout, exp);
    end
  endtask

  task automatic t_reset_state;
    apply("R8", 8'h00, 3'd0, 3'd0, 8'h00);
  endtask

  task automatic t_pass;
    for (int s = 0; s < 8; s++) apply("R1", 8'hA5, s[2:0], 3'b000, 8'hA5);
  endtask

  task automatic t_lsl;
    apply("R2", 8'h81, 3'd1, 3'b001, 8'h02);
    apply("R2", 8'h81, 3'd3, 3'b001, 8'h08);
    apply("R2", 8'hFF, 3'd7, 3'b001, 8'h80);
  endtask

  task automatic t_lsr;
    apply("R3", 8'h81, 3'd1, 3'b010, 8'h40);
    apply("R3", 8'hFF, 3'd7, 3'b010, 8'h01);
  endtask

  task automatic t_asr;
    apply("R4", 8'h81, 3'd1, 3'b011, 8'hC0);
    apply("R4", 8'hC0, 3'd3, 3'b011, 8'hF8);
    apply("R4", 8'h7F, 3'd7, 3'b011, 8'h00);
    apply("R4", 8'h80, 3'd7, 3'b011, 8'hFF);
  endtask

  task automatic t_rol;
    apply("R5", 8'h96, 3'd2, 3'b100, 8'h5A);
    apply("R5", 8'h81, 3'd7, 3'b100, 8'hC0);
  endtask

  task automatic t_ror;
    apply("R6", 8'h96, 3'd3, 3'b101, 8'hD2);
    apply("R6", 8'h81, 3'd1, 3'b101, 8'hC0);
  endtask

  task automatic t_reserved;
    apply("R7", 8'h3C, 3'd5, 3'b110, 8'h3C);
    apply("R7", 8'hC3, 3'd2, 3'b111, 8'hC3);
  endtask

  task automatic t_zero_amt;
    for (int o = 0; o < 8; o++) apply("R8", 8'h96, 3'd0, o[2:0], 8'h96);
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 8; s++)
        for (int x = 0; x < 256; x++)
          apply("R9 sweep", x[7:0], s[2:0], o[2:0], model(x[7:0], s[2:0], o[2:0]));
  endtask

  initial begin
    t_reset_state();
    t_pass();
    t_lsl();
    t_lsr();
    t_asr();
    t_rol();
    t_ror();
    t_reserved();
    t_zero_amt();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule